// File: doc/BRIEF.md
# Clause 22 Management Bus Master

This block drives the two-wire station-management bus used to configure and poll Ethernet PHYs. It produces the management clock (MDC) from the system clock and, for each transaction that software requests, shifts out a 32-bit preamble of ones followed by one 32-bit management frame on the data line (MDIO). On a read it releases the data line over the turnaround and data bits, captures the sixteen bits that the PHY returns, and places them in the low half of the frame register.

Software sees three registers. Writing the frame register starts a transaction when the bus is idle. The timing register sets the MDC half period and how long the data line is held after each falling MDC edge. The event register holds a completion flag that stays set until software writes a one to it, and it also shows a busy bit. The divider and the hold time are programmed independently, and both values are latched when a frame starts.

Top module: `mdio_master`

## Requirements
- R1: MDC is low while idle. During a frame it toggles every SPEED system clock cycles, so a period is 2×SPEED cycles. SPEED is timing register bits [6:1]. The first rising edge comes SPEED cycles after the frame starts.
- R2: A frame sends 32 ones and then frame register bits 31 down to 0, MSB first, one bit per MDC period. Each bit is valid at the rising MDC edge that follows it, and the frame contains 64 rising edges in total.
- R3: After each falling MDC edge, the data line changes exactly D cycles after that edge, where D = min(HOLD+1, SPEED−1). HOLD is timing register bits [10:8]. When D is 0, the data line changes on the same edge as MDC.
- R4: The opcode is frame bits [29:28]. When it is 2'b10 (read), the output enable is low for the last 18 bit times (turnaround and data). The bits sampled on the 16 data rising edges, first bit into bit 15, replace frame register bits [15:0]; bits [31:16] keep their written value. Any other opcode drives the line for the whole frame.
- R5: A frame ends on the falling MDC edge after the 64th rising edge, 128×SPEED cycles after it starts. At that edge busy drops, event bit 0 sets, the output enable goes low and MDC stays low.
- R6: Writing 1 to event register bit 0 clears it. Writing 0 leaves it unchanged.
- R7: A write to the frame register while busy is ignored. The stored word and the frame on the wire are both unchanged.
- R8: While SPEED is 0, writing the frame register stores the word but starts no frame. Busy, MDC and the event bit all stay 0.
- R9: After reset all registers read 0, MDC is low and the output enable is low.
- R10: Register addresses are 0 for the frame register, 1 for the timing register (only bits [6:1] and [10:8] are kept; the other bits read 0) and 2 for the event register (bit 0 is the event, bit 1 is busy).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value driven by the master |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line value seen at the pin |

## Verification
Write frames are swept over every SPEED from 1 to 4 and every HOLD from 0 to 4. This separates the case where the hold setting is used as programmed from the case where it is clamped to SPEED−1, and it includes the zero-delay case at SPEED 1. The frame words alternate their bits so that every hold interval can be measured on the wire. Read frames are run at two speeds with response words whose halves differ, which exposes bit-order and field-placement errors in the captured data. Separate runs cover a write that arrives mid-frame, a frame request while SPEED is zero, and both polarities of the clear-event write.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_W   = 32;
    localparam int SPD_W     = 6;
    localparam int HOLD_W    = 3;
    localparam int RD_W      = 16;
    localparam int TA_W      = 2;
    localparam int DLY_W     = HOLD_W + 1;
    localparam int REG_AW    = 2;
    localparam int SPD_LSB   = 1;
    localparam int HOLD_LSB  = 8;

    localparam logic [1:0] OP_RD = 2'b10;

    localparam logic [REG_AW-1:0] ADDR_FRAME = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_CFG   = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_EVT   = 2'd2;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int SPD_W = mdio_pkg::SPD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SPD_W-1:0] half,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    typedef struct packed {
        logic [SPD_W-1:0] cnt;
        logic             clk_lvl;
    } gen_t;

    gen_t g_d, g_q;
    logic tick;

    always_comb begin
        tick = run && ({1'b0, g_q.cnt} + 1'b1 == {1'b0, half});
        g_d  = g_q;
        if (!run) begin
            g_d = '0;
        end else if (tick) begin
            g_d.cnt     = '0;
            g_d.clk_lvl = ~g_q.clk_lvl;
        end else begin
            g_d.cnt = g_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign mdc  = g_q.clk_lvl;
    assign rise = tick & ~g_q.clk_lvl;
    assign fall = tick &  g_q.clk_lvl;
endmodule

// File: rtl/mdio_hold_timer.sv
module mdio_hold_timer #(
    parameter int DLY_W = mdio_pkg::DLY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             fall,
    input  logic [DLY_W-1:0] dly,
    output logic             adv
);
    typedef struct packed {
        logic [DLY_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!run) begin
            t_d.cnt = '0;
        end else if (fall && dly != '0) begin
            t_d.cnt = dly;
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
        if (dly == '0) adv = fall;
        else           adv = (t_q.cnt == DLY_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
    parameter int PRE_LEN = mdio_pkg::PRE_LEN,
    parameter int FRAME_W = mdio_pkg::FRAME_W,
    parameter int RD_W    = mdio_pkg::RD_W,
    parameter int TA_W    = mdio_pkg::TA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] word_in,
    input  logic               adv,
    input  logic               rise,
    input  logic               fall,
    input  logic               mdio_i,
    output logic               busy,
    output logic               bit_o,
    output logic               oe,
    output logic               done,
    output logic               is_rd,
    output logic [RD_W-1:0]    cap
);
    localparam int TOTAL      = PRE_LEN + FRAME_W;
    localparam int IDX_W      = $clog2(TOTAL);
    localparam int POS_W      = $clog2(FRAME_W);
    localparam int LAST       = TOTAL - 1;
    localparam int DATA_FIRST = TOTAL - RD_W;
    localparam int TA_FIRST   = DATA_FIRST - TA_W;
    localparam int OP_HI      = FRAME_W - 3;

    typedef struct packed {
        logic               busy;
        logic [IDX_W-1:0]   idx;
        logic [FRAME_W-1:0] word;
        logic               rd;
        logic [RD_W-1:0]    cap;
    } eng_t;

    eng_t e_d, e_q;
    logic [IDX_W-1:0] rel;
    logic [POS_W-1:0] pos;
    logic             in_pre;

    always_comb begin
        e_d  = e_q;
        done = 1'b0;
        if (!e_q.busy) begin
            if (start) begin
                e_d.busy = 1'b1;
                e_d.idx  = '0;
                e_d.word = word_in;
                e_d.rd   = (word_in[OP_HI -: 2] == mdio_pkg::OP_RD);
                e_d.cap  = '0;
            end
        end else begin
            if (fall && e_q.idx == IDX_W'(LAST)) begin
                e_d.busy = 1'b0;
                done     = 1'b1;
            end else if (adv && e_q.idx != IDX_W'(LAST)) begin
                e_d.idx = e_q.idx + 1'b1;
            end
            if (rise && e_q.rd && e_q.idx >= IDX_W'(DATA_FIRST)) begin
                e_d.cap = {e_q.cap[RD_W-2:0], mdio_i};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    always_comb begin
        in_pre = (e_q.idx < IDX_W'(PRE_LEN));
        rel    = e_q.idx - IDX_W'(PRE_LEN);
        pos    = POS_W'(FRAME_W - 1) - rel[POS_W-1:0];
        bit_o  = e_q.busy & (in_pre | e_q.word[pos]);
        oe     = e_q.busy & ~(e_q.rd & (e_q.idx >= IDX_W'(TA_FIRST)));
    end

    assign busy  = e_q.busy;
    assign is_rd = e_q.rd;
    assign cap   = e_q.cap;
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int FRAME_W  = mdio_pkg::FRAME_W,
    parameter int PRE_LEN  = mdio_pkg::PRE_LEN,
    parameter int SPD_W    = mdio_pkg::SPD_W,
    parameter int HOLD_W   = mdio_pkg::HOLD_W,
    parameter int RD_W     = mdio_pkg::RD_W,
    parameter int REG_AW   = mdio_pkg::REG_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic               reg_wen,
    input  logic [FRAME_W-1:0] reg_wdata,
    output logic [FRAME_W-1:0] reg_rdata,
    output logic               mdc,
    output logic               mdio_o,
    output logic               mdio_oe,
    input  logic               mdio_i
);
    localparam int DLY_W = HOLD_W + 1;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [SPD_W-1:0]   speed;
        logic [HOLD_W-1:0]  hold;
        logic               evt;
        logic [SPD_W-1:0]   spd_run;
        logic [DLY_W-1:0]   dly_run;
    } regs_t;

    regs_t r_d, r_q;

    logic             busy, done, is_rd, start;
    logic             rise, fall, adv;
    logic [RD_W-1:0]  cap;
    logic [DLY_W-1:0] hold_p1, dly_eff;
    logic [FRAME_W-1:0] frame_word;
    logic             speed_nz, evt_flag;

    always_comb begin
        hold_p1 = DLY_W'(r_q.hold) + 1'b1;
        if (int'(hold_p1) < int'(r_q.speed)) dly_eff = hold_p1;
        else                                 dly_eff = DLY_W'(r_q.speed - 1'b1);

        speed_nz = (r_q.speed != '0);
        start    = reg_wen && (reg_addr == mdio_pkg::ADDR_FRAME) && !busy && speed_nz;

        r_d = r_q;
        if (reg_wen) begin
            case (reg_addr)
                mdio_pkg::ADDR_FRAME: if (!busy) r_d.frame = reg_wdata;
                mdio_pkg::ADDR_CFG: begin
                    r_d.speed = reg_wdata[mdio_pkg::SPD_LSB +: SPD_W];
                    r_d.hold  = reg_wdata[mdio_pkg::HOLD_LSB +: HOLD_W];
                end
                mdio_pkg::ADDR_EVT: if (reg_wdata[0]) r_d.evt = 1'b0;
                default: ;
            endcase
        end
        if (start) begin
            r_d.spd_run = r_q.speed;
            r_d.dly_run = dly_eff;
        end
        if (done) begin
            r_d.evt = 1'b1;
            if (is_rd) r_d.frame[RD_W-1:0] = cap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            mdio_pkg::ADDR_FRAME: reg_rdata = r_q.frame;
            mdio_pkg::ADDR_CFG: begin
                reg_rdata[mdio_pkg::SPD_LSB +: SPD_W]   = r_q.speed;
                reg_rdata[mdio_pkg::HOLD_LSB +: HOLD_W] = r_q.hold;
            end
            mdio_pkg::ADDR_EVT: begin
                reg_rdata[0] = r_q.evt;
                reg_rdata[1] = busy;
            end
            default: ;
        endcase
    end

    assign frame_word = r_q.frame;
    assign evt_flag   = r_q.evt;

    mdio_mdc_gen #(.SPD_W(SPD_W)) u_mdc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .half  (r_q.spd_run),
        .mdc   (mdc),
        .rise  (rise),
        .fall  (fall)
    );

    mdio_hold_timer #(.DLY_W(DLY_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .fall  (fall),
        .dly   (r_q.dly_run),
        .adv   (adv)
    );

    mdio_frame_engine #(
        .PRE_LEN (PRE_LEN),
        .FRAME_W (FRAME_W),
        .RD_W    (RD_W),
        .TA_W    (mdio_pkg::TA_W)
    ) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .word_in (reg_wdata),
        .adv     (adv),
        .rise    (rise),
        .fall    (fall),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .bit_o   (mdio_o),
        .oe      (mdio_oe),
        .done    (done),
        .is_rd   (is_rd),
        .cap     (cap)
    );
endmodule

// File: rtl/mdio_master_checks.sv
module mdio_master_checks #(
    parameter int FRAME_W = mdio_pkg::FRAME_W,
    parameter int REG_AW  = mdio_pkg::REG_AW
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               done,
    input logic               mdc,
    input logic               mdio_o,
    input logic               mdio_oe,
    input logic               reg_wen,
    input logic [REG_AW-1:0]  reg_addr,
    input logic               speed_nz,
    input logic [FRAME_W-1:0] frame_word,
    input logic               evt_flag
);
    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc); // R1

    AST_BIT_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $stable(mdio_o)); // R2

    AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy); // R4

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !mdio_oe && !mdc)); // R5

    AST_EVT_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_flag) |-> $past(done)); // R5

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && reg_wen && reg_addr == mdio_pkg::ADDR_FRAME)
        |=> $stable(frame_word)); // R7

    AST_NO_START_SPEED0: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !speed_nz && reg_wen && reg_addr == mdio_pkg::ADDR_FRAME)
        |=> !busy); // R8
endmodule

bind mdio_master mdio_master_checks #(.FRAME_W(FRAME_W), .REG_AW(REG_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .reg_wen    (reg_wen),
    .reg_addr   (reg_addr),
    .speed_nz   (speed_nz),
    .frame_word (frame_word),
    .evt_flag   (evt_flag)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mdio_master uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic expb(input logic [31:0] w, input int i);
        if (i < 32) return 1'b1;
        return w[63 - i];
    endfunction

    function automatic logic [31:0] mkw(input logic [1:0] op, input logic [4:0] phy,
                                        input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, op, phy, ra, 2'b10, d};
    endfunction

    // Runs one frame and checks the wire against the requirements.
    task automatic run_frame(input int s, input int h, input logic [31:0] word,
                             input logic [15:0] resp, input bit inject,
                             input logic [31:0] other);
        bit   rd_op = (word[29:28] == 2'b10);
        int   eff = ((h + 1) < s) ? (h + 1) : (s - 1);
        int   lim = rd_op ? 46 : 64;
        int   n = 0, rises = 0, phase = 0;
        int   e_mdc = 0, e_bit = 0, e_oe = 0, e_hold = 0, hold_meas = 0;
        bit   prev_mdc = 0, meas = 0, oldb = 0;
        int   mcnt = 0;
        logic [31:0] v;
        wr(2'd1, (32'(s) << 1) | (32'(h) << 8));
        wr(2'd2, 32'h1);
        wr(2'd0, word);
        reg_addr = 2'd2; #1;
        while (n < 4000) begin
            if (!reg_rdata[1]) break;
            if (mdc != prev_mdc) begin
                if (phase != s) e_mdc++;
                phase = 1;
            end else phase++;
            if (mdc && !prev_mdc) begin
                if (meas) begin e_hold++; meas = 0; end
                if (rd_op && rises >= 46) begin
                    if (mdio_oe !== 1'b0) e_oe++;
                end else begin
                    if (mdio_oe !== 1'b1) e_oe++;
                    if (mdio_o !== expb(word, rises)) e_bit++;
                end
                rises++;
            end
            if (!mdc && prev_mdc) begin
                if (rd_op && rises >= 48 && rises < 64) mdio_i = resp[63 - rises];
                if (rises < lim && expb(word, rises) != expb(word, rises - 1)) begin
                    meas = 1; mcnt = 0; oldb = expb(word, rises - 1);
                end
            end else if (meas) mcnt++;
            if (meas && mdio_o != oldb) begin
                if (mcnt != eff) e_hold++;
                hold_meas++;
                meas = 0;
            end
            prev_mdc = mdc;
            if (inject && n == 10) begin
                reg_addr = 2'd0; reg_wdata = other; reg_wen = 1'b1;
            end
            @(negedge clk);
            reg_wen = 1'b0; reg_addr = 2'd2; #1;
            n++;
        end
        check(e_mdc == 0, $sformatf("R1 mdc phase length s=%0d", s), e_mdc, 0);
        check(e_bit == 0 && rises == 64, $sformatf("R2 serial bits s=%0d h=%0d rises", s, h), rises, 64);
        check(e_hold == 0 && hold_meas > 0, $sformatf("R3 hold delay s=%0d h=%0d errors", s, h), e_hold, 0);
        check(e_oe == 0, $sformatf("R4 output enable rd=%0d", rd_op), e_oe, 0);
        check(n == 128 * s, $sformatf("R5 frame length s=%0d", s), n, 128 * s);
        rd(2'd2, v);
        check(v[1:0] == 2'b01 && !mdio_oe && !mdc, "R5 end state event/busy", v[1:0], 1);
        rd(2'd0, v);
        if (rd_op)
            check(v == {word[31:16], resp}, "R4 captured read data", v, {word[31:16], resp});
        else
            check(v == word, "R7 frame register after frame", v, word);
        mdio_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        // R9 reset state
        check(mdc === 1'b0 && mdio_oe === 1'b0, "R9 outputs in reset", {mdc, mdio_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 3; a++) begin
            rd(2'(a), v);
            check(v == 32'h0, $sformatf("R9 register %0d after reset", a), v, 0);
        end
        // R10 timing register keeps only its fields
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v);
        check(v == 32'h0000_077E, "R10 timing register readback", v, 32'h77E);
        // R8 SPEED zero: word stored, nothing starts
        wr(2'd1, 32'h0000_0300);
        wr(2'd0, 32'h5A5A_1234);
        begin
            int act = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                rd(2'd2, v);
                if (v[1:0] != 2'b00 || mdc || mdio_oe) act++;
            end
            check(act == 0, "R8 no frame with SPEED 0", act, 0);
        end
        rd(2'd0, v);
        check(v == 32'h5A5A_1234, "R8 word stored at SPEED 0", v, 32'h5A5A_1234);
        // R1 R2 R3 R5 write sweep
        for (int s = 1; s <= 4; s++) begin
            for (int h = 0; h <= 4; h++) begin
                run_frame(s, h, mkw(2'b01, 5'(s * 7), 5'(h * 5 + 3), 16'hA5C3 ^ 16'(s * 16'h0F11 + h)),
                          16'h0, 1'b0, 32'h0);
            end
        end
        // R4 reads
        run_frame(1, 0, mkw(2'b10, 5'h03, 5'h01, 16'hFFFF), 16'hC0A5, 1'b0, 32'h0);
        run_frame(3, 2, mkw(2'b10, 5'h1E, 5'h11, 16'h0000), 16'h3B96, 1'b0, 32'h0);
        // R6 clear-on-write-one
        wr(2'd2, 32'h0);
        rd(2'd2, v);
        check(v[0] == 1'b1, "R6 write 0 keeps event", v[0], 1);
        wr(2'd2, 32'h1);
        rd(2'd2, v);
        check(v[0] == 1'b0, "R6 write 1 clears event", v[0], 0);
        // R7 write during busy is ignored
        run_frame(2, 1, mkw(2'b01, 5'h15, 5'h0A, 16'h6D29), 16'h0, 1'b1, 32'hFFFF_0000);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule